// File: doc/BRIEF.md
# Dual H-Bridge Gate Control Core

This block is the digital control core for a pair of independent H-bridges. Each bridge takes two logic inputs. A shared selection input picks how those inputs are read: either each input commands one output directly, or one input sets the direction while the other turns the bridge on. Every half-bridge output comes out as a high-side gate enable and a low-side gate enable. From these two enables the output pin can be driven high, driven low or left floating (coast).

The core also guards the switches. Any half-bridge that moves from one driven level to another first passes through a dead time with both switches off. A per-bridge overcurrent flag that stays asserted long enough locks that bridge off for a fixed retry interval, and the bridge then comes back by itself. A thermal flag holds every switch off while it is asserted. An undervoltage flag does the same and also clears all internal state. An active-low sleep input floats every output. The analog sensing and the power stage are outside this block and connect only through flag inputs and gate-enable outputs.

Top module: `hbridge_ctrl_core`

## Requirements
- R1: `mode_sel` low selects the direct scheme and `mode_sel` high selects the phase/enable scheme, for all bridges at once.
- R2: In the direct scheme, bridge inputs (in1,in2) give: 00 gives both outputs floating; 01 gives OUT1 low and OUT2 high; 10 gives OUT1 high and OUT2 low; 11 gives both low. Output 1 of bridge b is bit 2b of `hs_en`/`ls_en` and output 2 is bit 2b+1. A driven-high output has only its `hs_en` bit set, a driven-low output has only its `ls_en` bit set, and a floating output has neither.
- R3: In the phase/enable scheme, in2 is the enable and in1 is the phase. When in2=0 both outputs are low and in1 has no effect. When in2=1, in1=1 gives OUT1 low and OUT2 high, and in1=0 gives OUT1 high and OUT2 low.
- R4: While `sleep_n` is low, every enable is 0 from the first clock edge on.
- R5: When a half-bridge leaves a driven level, both of its enables stay 0 for DEAD_CYC+1 edges before any new driven level appears. The same dead time counts from the last edge of any forced-off period (sleep, thermal, undervoltage, lockout). A half-bridge that has been floating for at least DEAD_CYC edges takes a new level on the next edge.
- R6: A half-bridge never goes from high-side enabled to low-side enabled, or from low-side to high-side, on consecutive edges.
- R7: A bridge's overcurrent flag has to be sampled high on OCP_QUAL_CYC consecutive edges before that bridge locks. A shorter pulse has no effect.
- R8: A locked bridge has all of its enables 0 from the edge after locking. It unlocks by itself RETRY_CYC edges after locking, and the other bridge keeps running throughout.
- R9: While `therm_flag` is high, all enables are 0. Operation resumes after the flag clears, following the R5 dead time.
- R10: While `uv_flag` is high, all enables are 0 and any lockout and its timers are cleared. After the flag clears, a bridge that was locked resumes after only the R5 dead time.
- R11: `br_fault[b]` is 1 exactly while bridge b is locked. `any_fault` is the OR of `br_fault`, `therm_flag` and `uv_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep; floats every output |
| mode_sel | input | 1 | 0 = direct scheme, 1 = phase/enable scheme |
| in1 | input | NB | Per-bridge input 1 (phase in phase/enable scheme) |
| in2 | input | NB | Per-bridge input 2 (enable in phase/enable scheme) |
| ocp_flag | input | NB | Per-bridge overcurrent flag from either side |
| therm_flag | input | 1 | Over-temperature flag |
| uv_flag | input | 1 | Undervoltage flag |
| hs_en | output | 2*NB | High-side gate enables, bit 2b = OUT1, 2b+1 = OUT2 of bridge b |
| ls_en | output | 2*NB | Low-side gate enables, same bit order |
| br_fault | output | NB | Per-bridge overcurrent lockout status |
| any_fault | output | 1 | Any lockout, thermal or undervoltage condition |

## Verification
The hardest state to reach from the ports is an overcurrent lockout that is still pending when undervoltage arrives. Only in that state does it matter whether the retry timer is really cleared. The stimulus qualifies a lockout on bridge B with a flag held for the full qualification window. On the next edge it drops the flag and raises undervoltage. After release it expects bridge B to drive again after only the dead time, which is far sooner than the retry interval would allow. The full retry interval of a locked bridge A is also observed, edge by edge around the release, while bridge B keeps braking.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
   typedef enum logic [1:0] {
      HALF_OFF  = 2'd0,
      HALF_HIGH = 2'd1,
      HALF_LOW  = 2'd2
   } half_t;
endpackage

// File: rtl/hbc_decode.sv
module hbc_decode (
   input  logic           mode_sel,
   input  logic           in1,
   input  logic           in2,
   output hbc_pkg::half_t tgt1,
   output hbc_pkg::half_t tgt2
);
   import hbc_pkg::*;

   always_comb begin
      if (!mode_sel) begin
         unique case ({in1, in2})
            2'b00:   begin tgt1 = HALF_OFF;  tgt2 = HALF_OFF;  end
            2'b01:   begin tgt1 = HALF_LOW;  tgt2 = HALF_HIGH; end
            2'b10:   begin tgt1 = HALF_HIGH; tgt2 = HALF_LOW;  end
            default: begin tgt1 = HALF_LOW;  tgt2 = HALF_LOW;  end
         endcase
      end else if (!in2) begin
         tgt1 = HALF_LOW;  tgt2 = HALF_LOW;
      end else if (in1) begin
         tgt1 = HALF_LOW;  tgt2 = HALF_HIGH;
      end else begin
         tgt1 = HALF_HIGH; tgt2 = HALF_LOW;
      end
   end
endmodule

// File: rtl/hbc_ocp_guard.sv
module hbc_ocp_guard #(
   parameter int QUAL_CYC  = 300,
   parameter int RETRY_CYC = 100000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic hold,
   input  logic ocp_flag,
   output logic locked
);
   localparam int QW = $clog2(QUAL_CYC + 1);
   localparam int RW = $clog2(RETRY_CYC + 1);
   localparam logic [QW-1:0] Q_LAST = QW'(QUAL_CYC - 1);
   localparam logic [RW-1:0] R_LAST = RW'(RETRY_CYC - 1);

   logic [QW-1:0] qual_q;
   logic [RW-1:0] wait_q;
   logic          lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
         qual_q <= '0;
         wait_q <= '0;
      end else if (clr) begin
         lock_q <= 1'b0;
         qual_q <= '0;
         wait_q <= '0;
      end else if (lock_q) begin
         if (wait_q == R_LAST) begin
            lock_q <= 1'b0;
            qual_q <= '0;
         end else begin
            wait_q <= wait_q + RW'(1);
         end
      end else if (hold || !ocp_flag) begin
         qual_q <= '0;
      end else if (qual_q == Q_LAST) begin
         lock_q <= 1'b1;
         wait_q <= '0;
      end else begin
         qual_q <= qual_q + QW'(1);
      end
   end

   assign locked = lock_q;

   assert_lock_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_q) |-> $past(ocp_flag));

   assert_clr_unlocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !lock_q);
endmodule

// File: rtl/hbc_half_drive.sv
module hbc_half_drive #(
   parameter int DEAD_CYC = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           force_off,
   input  hbc_pkg::half_t tgt,
   output logic           hs_en,
   output logic           ls_en
);
   import hbc_pkg::*;

   localparam int DW = $clog2(DEAD_CYC + 1);
   localparam logic [DW-1:0] DEAD_LD = DW'(DEAD_CYC);

   half_t         cur_q, cur_d;
   logic [DW-1:0] dt_q, dt_d;

   always_comb begin
      cur_d = cur_q;
      dt_d  = dt_q;
      if (force_off) begin
         cur_d = HALF_OFF;
         dt_d  = DEAD_LD;
      end else if (tgt == cur_q) begin
         if (dt_q != '0) dt_d = dt_q - DW'(1);
      end else if (cur_q != HALF_OFF) begin
         cur_d = HALF_OFF;
         dt_d  = DEAD_LD;
      end else if (dt_q == '0) begin
         cur_d = tgt;
      end else begin
         dt_d = dt_q - DW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= HALF_OFF;
         dt_q  <= '0;
      end else begin
         cur_q <= cur_d;
         dt_q  <= dt_d;
      end
   end

   assign hs_en = (cur_q == HALF_HIGH);
   assign ls_en = (cur_q == HALF_LOW);

   assert_gap_after_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(hs_en) || $fell(ls_en)) |=> (!hs_en && !ls_en));

   assert_no_hi_to_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en |=> !ls_en);

   assert_no_lo_to_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ls_en |=> !hs_en);
endmodule

// File: rtl/hbridge_ctrl_core.sv
module hbridge_ctrl_core #(
   parameter int NB           = 2,
   parameter int DEAD_CYC     = 4,
   parameter int OCP_QUAL_CYC = 300,
   parameter int RETRY_CYC    = 100000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep_n,
   input  logic            mode_sel,
   input  logic [NB-1:0]   in1,
   input  logic [NB-1:0]   in2,
   input  logic [NB-1:0]   ocp_flag,
   input  logic            therm_flag,
   input  logic            uv_flag,
   output logic [2*NB-1:0] hs_en,
   output logic [2*NB-1:0] ls_en,
   output logic [NB-1:0]   br_fault,
   output logic            any_fault
);
   localparam int HALVES = 2 * NB;

   if (NB < 1) begin : g_bad_nb
      $error("NB must be at least 1");
   end
   if (DEAD_CYC < 1) begin : g_bad_dead
      $error("DEAD_CYC must be at least 1");
   end
   if (OCP_QUAL_CYC < 1 || RETRY_CYC < 1) begin : g_bad_timers
      $error("fault timers must be at least 1 cycle");
   end

   logic [NB-1:0] lock_w;
   logic          global_off;

   assign global_off = !sleep_n || therm_flag || uv_flag;

   for (genvar b = 0; b < NB; b++) begin : g_bridge
      hbc_pkg::half_t tgt_w [2];
      logic           off_w;

      hbc_decode u_dec (
         .mode_sel (mode_sel),
         .in1      (in1[b]),
         .in2      (in2[b]),
         .tgt1     (tgt_w[0]),
         .tgt2     (tgt_w[1])
      );

      hbc_ocp_guard #(
         .QUAL_CYC  (OCP_QUAL_CYC),
         .RETRY_CYC (RETRY_CYC)
      ) u_guard (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (uv_flag),
         .hold     (!sleep_n),
         .ocp_flag (ocp_flag[b]),
         .locked   (lock_w[b])
      );

      assign off_w = global_off || lock_w[b];

      for (genvar h = 0; h < 2; h++) begin : g_half
         hbc_half_drive #(
            .DEAD_CYC (DEAD_CYC)
         ) u_half (
            .clk       (clk),
            .rst_n     (rst_n),
            .force_off (off_w),
            .tgt       (tgt_w[h]),
            .hs_en     (hs_en[2*b+h]),
            .ls_en     (ls_en[2*b+h])
         );
      end

      assert_lock_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
         lock_w[b] |=> (hs_en[2*b +: 2] == 2'b00 && ls_en[2*b +: 2] == 2'b00));
   end

   assign br_fault  = lock_w;
   assign any_fault = (|lock_w) || therm_flag || uv_flag;

   assert_sleep_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_n |=> (hs_en == HALVES'(0) && ls_en == HALVES'(0)));

   assert_therm_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      therm_flag |=> (hs_en == HALVES'(0) && ls_en == HALVES'(0)));

   assert_uv_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> (hs_en == HALVES'(0) && ls_en == HALVES'(0) && br_fault == NB'(0)));
endmodule

// File: tb/sim_hbridge_ctrl_core.sv
module sim_hbridge_ctrl_core;
   localparam int NB    = 2;
   localparam int DEAD  = 3;
   localparam int QUAL  = 8;
   localparam int RETRY = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_n = 1'b1;
   logic          mode_sel = 1'b0;
   logic [NB-1:0] in1 = '0, in2 = '0, ocp_flag = '0;
   logic          therm_flag = 1'b0, uv_flag = 1'b0;
   logic [3:0]    hs_en, ls_en;
   logic [1:0]    br_fault;
   logic          any_fault;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   typedef struct {
      int         due;
      logic [3:0] hs;
      logic [3:0] ls;
      logic [1:0] bf;
      logic       af;
      string      tag;
   } item_t;

   item_t sb_q[$];
   item_t it;

   always #5 clk = ~clk;

   hbridge_ctrl_core #(
      .NB           (NB),
      .DEAD_CYC     (DEAD),
      .OCP_QUAL_CYC (QUAL),
      .RETRY_CYC    (RETRY)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_n    (sleep_n),
      .mode_sel   (mode_sel),
      .in1        (in1),
      .in2        (in2),
      .ocp_flag   (ocp_flag),
      .therm_flag (therm_flag),
      .uv_flag    (uv_flag),
      .hs_en      (hs_en),
      .ls_en      (ls_en),
      .br_fault   (br_fault),
      .any_fault  (any_fault)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops expectations as their edge has passed
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
         it = sb_q.pop_front();
         checks++;
         if (hs_en !== it.hs || ls_en !== it.ls || br_fault !== it.bf || any_fault !== it.af) begin
            errors++;
            $display("FAIL %s: got hs=%b ls=%b bf=%b af=%b, expected hs=%b ls=%b bf=%b af=%b",
                     it.tag, hs_en, ls_en, br_fault, any_fault, it.hs, it.ls, it.bf, it.af);
         end
      end
   end

   task automatic expect_at(input int k, input logic [3:0] h, input logic [3:0] l,
                            input logic [1:0] bf, input logic af, input string tag);
      item_t x;
      x.due = cyc + k; x.hs = h; x.ls = l; x.bf = bf; x.af = af; x.tag = tag;
      sb_q.push_back(x);
   endtask

   task automatic tick(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic set_br(input logic m, input logic a1, input logic a2,
                         input logic b1, input logic b2);
      mode_sel = m;
      in1 = {b1, a1};
      in2 = {b2, a2};
   endtask

   initial begin
      tick(3);
      checks++;
      if (hs_en !== 4'b0 || ls_en !== 4'b0 || br_fault !== 2'b0 || any_fault !== 1'b0) begin
         errors++;
         $display("FAIL R2 reset state: got hs=%b ls=%b bf=%b, expected all zero", hs_en, ls_en, br_fault);
      end
      rst_n = 1'b1;
      expect_at(1, 4'b0000, 4'b0000, 2'b00, 1'b0, "R2 idle after reset");
      tick(2);

      // R2 direct: A forward, B reverse
      set_br(1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
      expect_at(1, 4'b1001, 4'b0110, 2'b00, 1'b0, "R2 forward/reverse");
      tick(8);

      // R5 dead time on A reversal
      set_br(1'b0, 1'b0, 1'b1, 1'b0, 1'b1);
      expect_at(1, 4'b1000, 4'b0100, 2'b00, 1'b0, "R5 gap start");
      expect_at(4, 4'b1000, 4'b0100, 2'b00, 1'b0, "R5 gap end");
      expect_at(5, 4'b1010, 4'b0101, 2'b00, 1'b0, "R2 reverse after gap");
      tick(8);

      // R2 brake, OUT1 stays low undisturbed
      set_br(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      expect_at(1, 4'b1000, 4'b0101, 2'b00, 1'b0, "R5 brake gap");
      expect_at(5, 4'b1000, 4'b0111, 2'b00, 1'b0, "R2 brake");
      tick(8);

      // R2 coast
      set_br(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      expect_at(1, 4'b1000, 4'b0100, 2'b00, 1'b0, "R2 coast");
      tick(8);

      // R1/R3 phase/enable: A enabled phase 0, B disabled
      set_br(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
      expect_at(1, 4'b0001, 4'b0110, 2'b00, 1'b0, "R1 R3 forward");
      expect_at(5, 4'b0001, 4'b1110, 2'b00, 1'b0, "R3 disabled brake");
      tick(8);

      set_br(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
      expect_at(2, 4'b0001, 4'b1110, 2'b00, 1'b0, "R3 phase ignored when disabled");
      tick(4);

      set_br(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      expect_at(1, 4'b0000, 4'b1100, 2'b00, 1'b0, "R5 phase flip gap");
      expect_at(5, 4'b0010, 4'b1101, 2'b00, 1'b0, "R3 reverse");
      tick(8);

      // R4 sleep
      sleep_n = 1'b0;
      expect_at(1, 4'b0000, 4'b0000, 2'b00, 1'b0, "R4 sleep off");
      expect_at(3, 4'b0000, 4'b0000, 2'b00, 1'b0, "R4 sleep held");
      tick(4);
      sleep_n = 1'b1;
      expect_at(3, 4'b0000, 4'b0000, 2'b00, 1'b0, "R5 gap after sleep");
      expect_at(4, 4'b0010, 4'b1101, 2'b00, 1'b0, "R4 resume");
      tick(8);

      // R9 thermal
      therm_flag = 1'b1;
      expect_at(1, 4'b0000, 4'b0000, 2'b00, 1'b1, "R9 thermal off");
      tick(3);
      therm_flag = 1'b0;
      expect_at(3, 4'b0000, 4'b0000, 2'b00, 1'b0, "R9 gap after thermal");
      expect_at(4, 4'b0010, 4'b1101, 2'b00, 1'b0, "R9 resume");
      tick(8);

      // R7 short overcurrent pulse
      ocp_flag = 2'b01;
      expect_at(7, 4'b0010, 4'b1101, 2'b00, 1'b0, "R7 short pulse");
      tick(7);
      ocp_flag = 2'b00;
      expect_at(2, 4'b0010, 4'b1101, 2'b00, 1'b0, "R7 short pulse ignored");
      tick(4);

      // R7/R8/R11 qualified lockout on A with retry
      ocp_flag = 2'b01;
      expect_at(7,   4'b0010, 4'b1101, 2'b00, 1'b0, "R7 not yet qualified");
      expect_at(8,   4'b0010, 4'b1101, 2'b01, 1'b1, "R11 A fault status");
      expect_at(9,   4'b0000, 4'b1100, 2'b01, 1'b1, "R8 A off B kept");
      expect_at(207, 4'b0000, 4'b1100, 2'b01, 1'b1, "R8 still locked");
      expect_at(208, 4'b0000, 4'b1100, 2'b00, 1'b0, "R8 released");
      expect_at(211, 4'b0000, 4'b1100, 2'b00, 1'b0, "R5 gap after lockout");
      expect_at(212, 4'b0010, 4'b1101, 2'b00, 1'b0, "R8 resume");
      tick(9);
      ocp_flag = 2'b00;
      tick(210);

      // R10 undervoltage clears pending lockout on B
      ocp_flag = 2'b10;
      expect_at(8, 4'b0010, 4'b1101, 2'b10, 1'b1, "R11 B fault status");
      tick(8);
      ocp_flag = 2'b00;
      uv_flag  = 1'b1;
      expect_at(1, 4'b0000, 4'b0000, 2'b00, 1'b1, "R10 off and lock cleared");
      tick(3);
      uv_flag = 1'b0;
      expect_at(3, 4'b0000, 4'b0000, 2'b00, 1'b0, "R10 gap after release");
      expect_at(4, 4'b0010, 4'b1101, 2'b00, 1'b0, "R10 resume without retry wait");
      tick(8);

      wait (sb_q.size() == 0);
      tick(1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, %0d expectations pending", sb_q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule